// File: doc/BRIEF.md
# Sticky Event and Interrupt Aggregator

This block holds the event flags of a four-port power controller. Each port condition arrives as a one-cycle pulse and sets a flag that stays set. The flags are grouped into five 8-bit event registers. Each register can be read at two addresses. The even address only reads the register. The odd address reads it and clears it at the same clock edge.

An 8-bit summary ORs groups of event bits together. The summary is ANDed with a mask and with a global enable. A rising masked summary bit pulls the active-low interrupt request down. Software can release the request without touching any flag. It can also clear every flag at once with a single command.

The host reaches the registers through a simple strobe bus. The read data is combinational on `addr`. A write, and the clear caused by a clearing read, both take effect at the rising clock edge where the strobe is high.

Top module: `evt_irq_hub`

## Requirements
- R1: An event pulse sets its flag at the next clock edge. The flag then stays 1 through reads of the even address until it is cleared. Register map: 0x02 has power-on change in bits 3:0 and power-good change in bits 7:4. 0x04 has detect done in bits 3:0 and class done in bits 7:4. 0x06 has overcurrent in bits 3:0 and disconnect in bits 7:4. 0x08 has start fault in bits 3:0. 0x0A has the supply flags at bits 4, 5 and 7. In every nibble, bit n belongs to port n.
- R2: A read of the odd address (even address + 1) returns the same byte as the even address and clears that register at the clock edge. A pulse that arrives in the same cycle as that read stays set.
- R3: The summary at 0x00 has one bit per group. Bit0 is power-on change and bit1 is power-good change. Bit2 is detect done and bit3 is class done. Bit4 is overcurrent and bit5 is disconnect. Bit6 is start fault. Bit7 is the OR of supply bits 4, 5 and 7.
- R4: Reserved bits always read 0. These are bits 7:4 of 0x08, bits 3:0 and 6 of 0x0A, and the command register 0x0D.
- R5: Writes to the summary address have no effect. The summary changes only when the event flags change.
- R6: `irq_n` goes low one clock edge after a summary bit that is unmasked in the mask register 0x01 rises to 1. A summary bit that is masked never asserts `irq_n`. The mask never changes what the summary reads.
- R7: Bit 7 of the control register 0x0C is the interrupt enable, and it resets to 1. While it is 0, `irq_n` stays high.
- R8: Writing bit 6 of 0x0D releases `irq_n` and leaves every flag unchanged. `irq_n` asserts again only when some masked summary bit newly rises.
- R9: Writing bit 7 of 0x0D clears all event registers and the summary, and releases `irq_n`.
- R10: `irq_n` returns high one edge after the masked summary becomes all zero.
- R11: After reset, all event registers read 0x00, the mask reads 0x00, the control register reads 0x80 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (needed for clear-on-read) |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ev_pwr_on | input | 4 | Per-port power-on change pulses |
| ev_pwr_good | input | 4 | Per-port power-good change pulses |
| ev_det | input | 4 | Per-port detect-done pulses |
| ev_cls | input | 4 | Per-port class-done pulses |
| ev_ocur | input | 4 | Per-port overcurrent pulses |
| ev_disc | input | 4 | Per-port disconnect pulses |
| ev_start | input | 4 | Per-port start-fault pulses |
| ev_supply | input | 3 | Supply pulses, feeding bits 4, 5 and 7 of 0x0A |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Single pulses are sent on each source in turn. This shows whether the flag lands in the right register bit and the right summary bit. Pairs of pulses in one register show that a clearing read removes every bit at once. A pulse timed to coincide with a clearing read shows whether set wins over clear. For the interrupt, mask-off, enable-off, release and re-pulse sequences are contrasted. A second pulse into an already-set summary bit must not re-assert after a release, while a pulse into a different bit must. This separates edge detection from level detection.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NPORT = 4;
  localparam int DW    = 2 * NPORT;
  localparam int NREG  = 5;
  localparam int AW    = 5;

  localparam logic [AW-1:0] A_SUM  = 5'h00;
  localparam logic [AW-1:0] A_MASK = 5'h01;
  localparam logic [AW-1:0] A_EV0  = 5'h02;
  localparam logic [AW-1:0] A_CTRL = 5'h0C;
  localparam logic [AW-1:0] A_CMD  = 5'h0D;

  localparam int CMD_RELEASE = 6;
  localparam int CMD_CLRALL  = 7;
  localparam int CTRL_EN     = 7;

  // bits of each event register that can ever be set
  function automatic logic [DW-1:0] keep_bits(input int idx);
    case (idx)
      3:       keep_bits = 8'h0F;
      4:       keep_bits = 8'hB0;
      default: keep_bits = 8'hFF;
    endcase
  endfunction

  // fold the five event registers into the eight summary bits
  function automatic logic [7:0] fold_summary(input logic [NREG*DW-1:0] ev);
    logic [DW-1:0] pw, dt, ft, st, sp;
    pw = ev[0*DW +: DW];
    dt = ev[1*DW +: DW];
    ft = ev[2*DW +: DW];
    st = ev[3*DW +: DW];
    sp = ev[4*DW +: DW];
    fold_summary = {sp[7] | sp[5] | sp[4], |st[3:0],
                    |ft[7:4], |ft[3:0], |dt[7:4], |dt[3:0],
                    |pw[7:4], |pw[3:0]};
  endfunction
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int W = 8,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~{W{clr}}) | set) & KEEP;
  end
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] masked,
  input  logic         release_cmd,
  input  logic         clear_all,
  output logic         rise_any,
  output logic         irq_n
);
  logic [N-1:0] masked_q;
  logic         pend_q;

  assign rise_any = |(masked & ~masked_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      masked_q <= masked;
      if (release_cmd || clear_all) pend_q <= 1'b0;
      else                          pend_q <= (pend_q & (|masked)) | rise_any;
    end
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NPORT-1:0] ev_pwr_on,
  input  logic [NPORT-1:0] ev_pwr_good,
  input  logic [NPORT-1:0] ev_det,
  input  logic [NPORT-1:0] ev_cls,
  input  logic [NPORT-1:0] ev_ocur,
  input  logic [NPORT-1:0] ev_disc,
  input  logic [NPORT-1:0] ev_start,
  input  logic [2:0]       ev_supply,
  output logic          irq_n
);
  logic [NREG*DW-1:0] set_all;
  logic [NREG*DW-1:0] ev_all;
  logic [NREG-1:0]    clr_vec;
  logic [7:0]         summary;
  logic [7:0]         masked;
  logic [7:0]         mask_q;
  logic               en_q;
  logic               release_cmd;
  logic               clear_all;
  logic               rise_any;

  assign set_all = {ev_supply[2], 1'b0, ev_supply[1:0], 4'b0000,
                    {NPORT{1'b0}}, ev_start,
                    ev_disc, ev_ocur,
                    ev_cls, ev_det,
                    ev_pwr_good, ev_pwr_on};

  assign release_cmd = wr_en && (addr == A_CMD) && wdata[CMD_RELEASE];
  assign clear_all   = wr_en && (addr == A_CMD) && wdata[CMD_CLRALL];

  for (genvar g = 0; g < NREG; g++) begin : g_ev
    localparam logic [AW-1:0] A_COR = A_EV0 + AW'(2 * g + 1);
    assign clr_vec[g] = clear_all || (rd_en && (addr == A_COR));
    evt_latch #(.W(DW), .KEEP(keep_bits(g))) u_ev (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_all[g*DW +: DW]),
      .clr  (clr_vec[g]),
      .q    (ev_all[g*DW +: DW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b1;
    end else if (wr_en) begin
      if (addr == A_MASK) mask_q <= wdata;
      if (addr == A_CTRL) en_q   <= wdata[CTRL_EN];
    end
  end

  assign summary = fold_summary(ev_all);
  assign masked  = summary & mask_q & {8{en_q}};

  irq_gen #(.N(8)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .masked     (masked),
    .release_cmd(release_cmd),
    .clear_all  (clear_all),
    .rise_any   (rise_any),
    .irq_n      (irq_n)
  );

  always_comb begin
    rdata = '0;
    if (addr == A_SUM)       rdata = summary;
    else if (addr == A_MASK) rdata = mask_q;
    else if (addr == A_CTRL) rdata = {en_q, 7'b0};
    else if (addr >= A_EV0 && addr < A_EV0 + AW'(2 * NREG))
      rdata = ev_all[((addr - A_EV0) >> 1) * DW +: DW];
  end
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk
  import evt_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      rdata,
  input logic               irq_n,
  input logic               en_q,
  input logic               release_cmd,
  input logic               clear_all,
  input logic [NREG-1:0]    clr_vec,
  input logic [NREG*DW-1:0] set_all,
  input logic [NREG*DW-1:0] ev_all,
  input logic [7:0]         masked
);
  // R1: flags never fall without a clear
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> (($past(ev_all) & ~ev_all) == '0));

  // R4: reserved nibble of the start-fault register reads 0
  a_r4_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 5'h08) |-> (rdata[7:4] == 4'h0));

  // R7: disabled interrupt stays high
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> irq_n);

  // R8: release deasserts the request
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_cmd |=> irq_n);

  // R9: clear-all empties every register when nothing fires
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_all && set_all == '0) |=> (ev_all == '0 && irq_n));

  // R6: an asserted request was backed by a masked summary bit
  a_r6_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(|masked));

  // R2: a clearing read only keeps bits that were pulsed
  a_r2_cor_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'h03) |=> (ev_all[7:0] == $past(set_all[7:0])));
endmodule

bind evt_irq_hub evt_irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq_n(irq_n), .en_q(en_q), .release_cmd(release_cmd), .clear_all(clear_all),
  .clr_vec(clr_vec), .set_all(set_all), .ev_all(ev_all), .masked(masked)
);

// File: tb/tb_evt_irq_hub.sv
module tb_evt_irq_hub;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] ev_pwr_on = '0, ev_pwr_good = '0, ev_det = '0, ev_cls = '0;
  logic [3:0] ev_ocur = '0, ev_disc = '0, ev_start = '0;
  logic [2:0] ev_supply = '0;
  logic irq_n;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  evt_irq_hub dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  // read; rdata sampled before the edge
  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_clear();
    ev_pwr_on = '0; ev_pwr_good = '0; ev_det = '0; ev_cls = '0;
    ev_ocur = '0; ev_disc = '0; ev_start = '0; ev_supply = '0;
  endtask

  task automatic expect_reg(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    check("R11 irq_n", {7'b0, irq_n}, 8'h01);
    for (int a = 0; a < 12; a++) expect_reg("R11 reg", 5'(a), 8'h00);
    expect_reg("R11 ctrl", 5'h0C, 8'h80);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    ev_det = 4'b0100; @(negedge clk); pulse_clear();
    expect_reg("R1 det", 5'h04, 8'h04);
    expect_reg("R1 det held", 5'h04, 8'h04);
    expect_reg("R3 det sum", 5'h00, 8'h04);
    ev_cls = 4'b0010; @(negedge clk); pulse_clear();
    expect_reg("R3 cls sum", 5'h00, 8'h0C);
    rd(5'h05, d);
    check("R2 cor data", d, 8'h24);
    expect_reg("R2 cleared", 5'h04, 8'h00);
    expect_reg("R2 sum cleared", 5'h00, 8'h00);
  endtask

  task automatic t_map();
    ev_pwr_on = 4'b0001; @(negedge clk); pulse_clear();
    expect_reg("R3 pwr on sum", 5'h00, 8'h01);
    ev_pwr_good = 4'b1000; @(negedge clk); pulse_clear();
    expect_reg("R1 pwr reg", 5'h02, 8'h81);
    expect_reg("R3 pwr good sum", 5'h00, 8'h03);
    ev_disc = 4'b0010; @(negedge clk); pulse_clear();
    expect_reg("R3 disc sum", 5'h00, 8'h23);
    ev_ocur = 4'b0001; @(negedge clk); pulse_clear();
    expect_reg("R3 ocur sum", 5'h00, 8'h33);
    ev_supply = 3'b010; @(negedge clk); pulse_clear();
    expect_reg("R1 supply reg", 5'h0A, 8'h20);
    expect_reg("R3 supply sum", 5'h00, 8'hB3);
    wr(5'h0D, 8'h80);
  endtask

  task automatic t_reserved();
    ev_start = 4'hF; ev_supply = 3'b111; @(negedge clk); pulse_clear();
    expect_reg("R4 start reg", 5'h08, 8'h0F);
    expect_reg("R3 start sum", 5'h00, 8'hC0);
    expect_reg("R4 supply reg", 5'h0A, 8'hB0);
    expect_reg("R4 cmd reads 0", 5'h0D, 8'h00);
    wr(5'h00, 8'h00);
    expect_reg("R5 sum after write 0", 5'h00, 8'hC0);
    wr(5'h0D, 8'h80);
    wr(5'h00, 8'hFF);
    expect_reg("R5 sum after write FF", 5'h00, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    ev_ocur = 4'b0001; @(negedge clk); pulse_clear();
    ev_ocur = 4'b0010;
    rd(5'h07, d);
    pulse_clear();
    check("R2 cor read", d, 8'h01);
    expect_reg("R2 pulse kept", 5'h06, 8'h02);
    wr(5'h0D, 8'h80);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    ev_det = 4'b0001; @(negedge clk); pulse_clear();
    tick(2);
    check("R6 masked off", {7'b0, irq_n}, 8'h01);
    expect_reg("R6 sum unaffected", 5'h00, 8'h04);
    wr(5'h01, 8'h04);
    check("R6 before edge", {7'b0, irq_n}, 8'h01);
    tick(1);
    check("R6 asserted", {7'b0, irq_n}, 8'h00);
    expect_reg("R6 mask readback", 5'h01, 8'h04);
    rd(5'h05, d);
    tick(1);
    check("R10 deassert", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_enable();
    wr(5'h01, 8'hFF);
    wr(5'h0C, 8'h00);
    expect_reg("R7 ctrl off", 5'h0C, 8'h00);
    ev_disc = 4'b0100; @(negedge clk); pulse_clear();
    tick(2);
    check("R7 quiet", {7'b0, irq_n}, 8'h01);
    wr(5'h0C, 8'h80);
    tick(1);
    check("R7 re-enabled", {7'b0, irq_n}, 8'h00);
    wr(5'h0D, 8'h80);
    tick(1);
  endtask

  task automatic t_release();
    ev_ocur = 4'b0001; @(negedge clk); pulse_clear();
    tick(1);
    check("R8 asserted", {7'b0, irq_n}, 8'h00);
    wr(5'h0D, 8'h40);
    check("R8 released", {7'b0, irq_n}, 8'h01);
    expect_reg("R8 flags kept", 5'h06, 8'h01);
    ev_ocur = 4'b0100; @(negedge clk); pulse_clear();
    tick(2);
    check("R8 same bit no reassert", {7'b0, irq_n}, 8'h01);
    ev_det = 4'b0001; @(negedge clk); pulse_clear();
    tick(1);
    check("R8 new bit reasserts", {7'b0, irq_n}, 8'h00);
  endtask

  task automatic t_clear_all();
    wr(5'h0D, 8'h80);
    check("R9 irq released", {7'b0, irq_n}, 8'h01);
    for (int a = 2; a < 12; a++) expect_reg("R9 reg cleared", 5'(a), 8'h00);
    expect_reg("R9 sum cleared", 5'h00, 8'h00);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_sticky();
    t_map();
    t_reserved();
    t_collide();
    t_mask();
    t_enable();
    t_release();
    t_clear_all();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule